// File: doc/BRIEF.md
# Serial Clock Chip with Parameter RAM

This block is a timekeeping chip driven by a host over a three-wire serial link: a chip-enable strobe, a shift clock and a data line. The data line is split into a data-in pin, a data-out pin and an output-enable pin, so the pad ring can build the bidirectional pin. Each transfer opens with an eight-bit command byte, sent most significant bit first. The command picks a direction and one target. The targets are one of four bytes of a 32-bit seconds counter, a write-only write-protect register, a write-only test register, or one of 20 bytes of battery-backed parameter RAM.

A read command makes the block load the chosen byte and shift it out over the next eight shift clocks. A write command takes one more byte, which is committed once its eighth bit arrives. A one-cycle tick pulse, once per second, advances the seconds counter. The serial pins are sampled with the system clock, so the shift clock must stay well below the system clock rate. The link has no back-pressure: the host sets the pace, and a transfer can be cut short at any point by dropping chip enable.

Top module: `rtc_serial_pram`

## Requirements
- R1: While `ce_i` is high, a bit is taken from `sdi_i` at each rising edge of `sclk_i`, most significant bit first. The first eight bits form the command byte. Command bit 7 set means read and clear means write.
- R2: A command whose bits [6:4] are 000 and bits [1:0] are 01 addresses seconds byte n, where n = bits [3:2]. Byte 0 is the least significant byte of the counter.
- R3: A command with bit 6 set and bits [1:0] = 01 addresses parameter RAM byte bits [5:2], in the range 0 to 15.
- R4: A command that gives 0x21 when masked with 0x73 addresses parameter RAM byte 16 + bits [3:2], in the range 16 to 19.
- R5: After a valid read command, the addressed byte appears on `sdo_o` MSB first. Each bit is valid before the shift-clock rise that ends it. `sdo_en_o` is high for exactly the eight data clocks and low at all other times.
- R6: After a valid write command, the next eight bits form the data byte. It is committed only when its eighth bit arrives.
- R7: Writing command 0x35 sets the write-protect flag to data bit 0. While the flag is set, writes to seconds bytes and parameter RAM are ignored. Writes to 0x35 are always accepted. Writes to the test register (command 0x31) change no other state.
- R8: Each `tick_i` pulse adds one to the 32-bit seconds counter, with carry across bytes and wrap from all ones to zero. Ticks also count while write protect is set.
- R9: Dropping `ce_i` abandons a partial transfer without committing anything. The next byte after `ce_i` rises again is a fresh command.
- R10: Any other command is ignored and causes no output and no state change. This includes reads of 0x31 and 0x35 and all extended-memory commands.
- R11: After reset, the counter, all RAM bytes and the write-protect flag are zero, and `sdo_en_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_i | input | 1 | Chip enable; high frames a transfer |
| sclk_i | input | 1 | Serial shift clock from host |
| sdi_i | input | 1 | Serial data from host |
| tick_i | input | 1 | One-cycle pulse, once per second |
| sdo_o | output | 1 | Serial read data to host |
| sdo_en_o | output | 1 | Drive enable for the shared data pin |

## Verification
If the bit counter drifts away from the byte boundary, every later command is framed wrongly. The first read after that returns a wrong byte or no byte at all, so the abort tests follow a cut-short frame with a full read. A stuck or misapplied write-protect flag shows only when a later read returns RAM or seconds contents that differ from the host's model. For that reason, every protected write is followed at once by a read of the same location. A counter that mishandles carries shows on the seconds byte one above the one that overflowed, within a single tick.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int RTC_SEC_BYTES    = 4;
  localparam int RTC_PRAM_BYTES   = 20;
  localparam int RTC_PRAM_AW      = $clog2(RTC_PRAM_BYTES);
  localparam int RTC_PRAM_HI_BASE = 16;

  typedef enum logic [2:0] {
    TGT_NONE,
    TGT_SEC,
    TGT_TEST,
    TGT_WP,
    TGT_PRAM
  } rtc_tgt_e;

  typedef struct packed {
    logic                   rd;
    rtc_tgt_e               tgt;
    logic [RTC_PRAM_AW-1:0] addr;
  } rtc_cmd_t;
endpackage

// File: rtl/rtc_cmd_decode.sv
module rtc_cmd_decode
  import rtc_pkg::*;
(
  input  logic [7:0] cmd_i,
  output rtc_cmd_t   dec_o
);
  always_comb begin
    dec_o.rd   = cmd_i[7];
    dec_o.tgt  = TGT_NONE;
    dec_o.addr = '0;
    if (cmd_i[6:4] == 3'b000 && cmd_i[1:0] == 2'b01) begin
      dec_o.tgt  = TGT_SEC;
      dec_o.addr = RTC_PRAM_AW'(cmd_i[3:2]);
    end else if (cmd_i[6:0] == 7'h31 && !cmd_i[7]) begin
      dec_o.tgt = TGT_TEST;
    end else if (cmd_i[6:0] == 7'h35 && !cmd_i[7]) begin
      dec_o.tgt = TGT_WP;
    end else if ((cmd_i & 8'h73) == 8'h21) begin
      dec_o.tgt  = TGT_PRAM;
      dec_o.addr = RTC_PRAM_AW'(RTC_PRAM_HI_BASE) + RTC_PRAM_AW'(cmd_i[3:2]);
    end else if (cmd_i[6] && cmd_i[1:0] == 2'b01) begin
      dec_o.tgt  = TGT_PRAM;
      dec_o.addr = RTC_PRAM_AW'(cmd_i[5:2]);
    end
  end
endmodule

// File: rtl/rtc_shift_if.sv
module rtc_shift_if #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_i,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              go_rd_i,
  input  logic              go_wr_i,
  input  logic [BYTE_W-1:0] rd_byte_i,
  output logic              cmd_done_o,
  output logic              wr_done_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              sdo_o,
  output logic              sdo_en_o
);
  typedef enum logic [1:0] {PH_CMD, PH_RD, PH_WR, PH_HOLD} phase_e;

  phase_e            phase_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-2:0] shreg_q;
  logic [BYTE_W-1:0] obuf_q;
  logic              ce_s, sclk_s, sclk_d, sdi_s;
  logic              rise, last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_s   <= 1'b0;
      sclk_s <= 1'b0;
      sclk_d <= 1'b0;
      sdi_s  <= 1'b0;
    end else begin
      ce_s   <= ce_i;
      sclk_s <= sclk_i;
      sclk_d <= sclk_s;
      sdi_s  <= sdi_i;
    end
  end

  assign rise       = ce_s && sclk_s && !sclk_d;
  assign last_bit   = (cnt_q == CNT_W'(BYTE_W - 1));
  assign byte_o     = {shreg_q, sdi_s};
  assign cmd_done_o = rise && last_bit && (phase_q == PH_CMD);
  assign wr_done_o  = rise && last_bit && (phase_q == PH_WR);
  assign sdo_en_o   = (phase_q == PH_RD);
  assign sdo_o      = sdo_en_o ? obuf_q[BYTE_W-1] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CMD;
      cnt_q   <= '0;
      shreg_q <= '0;
      obuf_q  <= '0;
    end else if (!ce_s) begin
      phase_q <= PH_CMD;
      cnt_q   <= '0;
    end else if (rise) begin
      cnt_q <= cnt_q + 1'b1;
      case (phase_q)
        PH_CMD: begin
          shreg_q <= byte_o[BYTE_W-2:0];
          if (last_bit) begin
            if (go_rd_i) begin
              phase_q <= PH_RD;
              obuf_q  <= rd_byte_i;
            end else if (go_wr_i) begin
              phase_q <= PH_WR;
            end else begin
              phase_q <= PH_HOLD;
            end
          end
        end
        PH_RD: begin
          obuf_q <= {obuf_q[BYTE_W-2:0], 1'b0};
          if (last_bit) phase_q <= PH_HOLD;
        end
        PH_WR: begin
          shreg_q <= byte_o[BYTE_W-2:0];
          if (last_bit) phase_q <= PH_HOLD;
        end
        default: phase_q <= PH_HOLD;
      endcase
    end
  end
endmodule

// File: rtl/rtc_store.sv
module rtc_store
  import rtc_pkg::*;
#(
  parameter int SEC_BYTES  = RTC_SEC_BYTES,
  parameter int PRAM_BYTES = RTC_PRAM_BYTES,
  localparam int SEC_W  = SEC_BYTES * 8,
  localparam int SIDX_W = $clog2(SEC_BYTES),
  localparam int PA_W   = $clog2(PRAM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              sec_we_i,
  input  logic [SIDX_W-1:0] sec_widx_i,
  input  logic              pram_we_i,
  input  logic [PA_W-1:0]   pram_waddr_i,
  input  logic [7:0]        wdata_i,
  input  logic [SIDX_W-1:0] sec_ridx_i,
  input  logic [PA_W-1:0]   pram_raddr_i,
  output logic [7:0]        sec_rdata_o,
  output logic [7:0]        pram_rdata_o,
  output logic [SEC_W-1:0]  sec_o
);
  logic [SEC_W-1:0] sec_q, sec_nxt;
  logic [7:0]       pram_q [PRAM_BYTES];

  always_comb begin
    sec_nxt = sec_q + SEC_W'(tick_i);
    if (sec_we_i) sec_nxt[{sec_widx_i, 3'b000} +: 8] = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sec_q <= '0;
    else        sec_q <= sec_nxt;
  end

  for (genvar g = 0; g < PRAM_BYTES; g++) begin : g_pram
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pram_q[g] <= '0;
      else if (pram_we_i && pram_waddr_i == PA_W'(g))
        pram_q[g] <= wdata_i;
    end
  end

  assign sec_rdata_o  = sec_q[{sec_ridx_i, 3'b000} +: 8];
  assign pram_rdata_o = (int'(pram_raddr_i) < PRAM_BYTES) ? pram_q[pram_raddr_i] : 8'h00;
  assign sec_o        = sec_q;
endmodule

// File: rtl/rtc_serial_pram.sv
module rtc_serial_pram
  import rtc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ce_i,
  input  logic sclk_i,
  input  logic sdi_i,
  input  logic tick_i,
  output logic sdo_o,
  output logic sdo_en_o
);
  localparam int SEC_W  = RTC_SEC_BYTES * 8;
  localparam int SIDX_W = $clog2(RTC_SEC_BYTES);

  rtc_cmd_t               dec_now;
  rtc_tgt_e               tgt_q;
  logic [RTC_PRAM_AW-1:0] addr_q;
  logic                   wp_q;
  logic                   cmd_done, wr_done, go_rd, go_wr;
  logic [7:0]             byte_now, rd_byte, sec_rdata, pram_rdata;
  logic                   sec_we, pram_we;
  logic [SEC_W-1:0]       sec_q;

  rtc_shift_if #(.BYTE_W(8)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .ce_i       (ce_i),
    .sclk_i     (sclk_i),
    .sdi_i      (sdi_i),
    .go_rd_i    (go_rd),
    .go_wr_i    (go_wr),
    .rd_byte_i  (rd_byte),
    .cmd_done_o (cmd_done),
    .wr_done_o  (wr_done),
    .byte_o     (byte_now),
    .sdo_o      (sdo_o),
    .sdo_en_o   (sdo_en_o)
  );

  rtc_cmd_decode u_dec (
    .cmd_i (byte_now),
    .dec_o (dec_now)
  );

  assign go_rd   = dec_now.rd && (dec_now.tgt == TGT_SEC || dec_now.tgt == TGT_PRAM);
  assign go_wr   = !dec_now.rd && (dec_now.tgt != TGT_NONE);
  assign rd_byte = (dec_now.tgt == TGT_SEC) ? sec_rdata : pram_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_q  <= TGT_NONE;
      addr_q <= '0;
    end else if (cmd_done) begin
      tgt_q  <= dec_now.tgt;
      addr_q <= dec_now.addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            wp_q <= 1'b0;
    else if (wr_done && tgt_q == TGT_WP)   wp_q <= byte_now[0];
  end

  assign sec_we  = wr_done && (tgt_q == TGT_SEC)  && !wp_q;
  assign pram_we = wr_done && (tgt_q == TGT_PRAM) && !wp_q;

  rtc_store u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .sec_we_i     (sec_we),
    .sec_widx_i   (addr_q[SIDX_W-1:0]),
    .pram_we_i    (pram_we),
    .pram_waddr_i (addr_q),
    .wdata_i      (byte_now),
    .sec_ridx_i   (dec_now.addr[SIDX_W-1:0]),
    .pram_raddr_i (dec_now.addr),
    .sec_rdata_o  (sec_rdata),
    .pram_rdata_o (pram_rdata),
    .sec_o        (sec_q)
  );
endmodule

// File: rtl/rtc_serial_pram_chk.sv
module rtc_serial_pram_chk #(
  parameter int SEC_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ce_i,
  input logic             sclk_i,
  input logic             tick_i,
  input logic             sdo_o,
  input logic             sdo_en_o,
  input logic             wp_q,
  input logic             sec_we,
  input logic [SEC_W-1:0] sec_q
);
  // R5: read data only moves after a shift-clock rise seen at the pins
  a_r5_sdo_moves_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_en_o && $past(sdo_en_o) && !($past(sclk_i, 2) && !$past(sclk_i, 3)))
      |-> $stable(sdo_o));

  // R9: chip enable low releases the data pin
  a_r9_ce_low_releases: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(ce_i, 2) |-> !sdo_en_o);

  // R7: protected counter only changes by ticks
  a_r7_wp_freezes_seconds: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wp_q) && !$past(tick_i)) |-> $stable(sec_q));

  // R8: a tick without a write adds exactly one
  a_r8_tick_adds_one: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(tick_i) && !$past(sec_we)) |-> (sec_q == $past(sec_q) + 1'b1));

  // R8: no tick and no write keeps the counter
  a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tick_i) && !$past(sec_we)) |-> $stable(sec_q));
endmodule

bind rtc_serial_pram rtc_serial_pram_chk #(.SEC_W(32)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ce_i     (ce_i),
  .sclk_i   (sclk_i),
  .tick_i   (tick_i),
  .sdo_o    (sdo_o),
  .sdo_en_o (sdo_en_o),
  .wp_q     (wp_q),
  .sec_we   (sec_we),
  .sec_q    (sec_q)
);

// File: tb/rtc_serial_pram_tb.sv
module rtc_serial_pram_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;
  localparam int WD_CYCLES  = 150000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ce = 1'b0, sclk = 1'b0, sdi = 1'b0, tick = 1'b0;
  logic sdo, sdo_en;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  int         mon_bits = 0;
  logic [7:0] mon_byte = '0;

  logic [7:0]  pm [20];
  logic [31:0] sm = '0;
  bit          wpm = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_serial_pram u_dut (
    .clk(clk), .rst_n(rst_n), .ce_i(ce), .sclk_i(sclk), .sdi_i(sdi),
    .tick_i(tick), .sdo_o(sdo), .sdo_en_o(sdo_en)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // monitor: collect read bytes at host sample points and score them
  initial begin
    forever begin
      @(posedge sclk);
      if (sdo_en) begin
        mon_byte = {mon_byte[6:0], sdo};
        mon_bits++;
        if (mon_bits == 8) begin
          mon_bits = 0;
          if (exp_q.size() == 0) check(1'b0, "R10 unexpected byte", 32'(mon_byte), 32'h0);
          else begin
            automatic logic [7:0] e = exp_q.pop_front();
            automatic string t = tag_q.pop_front();
            check(mon_byte == e, t, 32'(mon_byte), 32'(e));
          end
        end
      end
    end
  end

  task automatic send_bits(input logic [7:0] v, input int n, inout int en_seen);
    for (int i = 7; i > 7 - n; i--) begin
      @(negedge clk) sdi = v[i];
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      if (sdo_en) en_seen++;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic end_frame();
    repeat (HALF) @(negedge clk);
    ce = 1'b0;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] cmd, input logic [7:0] data, input int ndata, output int en_seen);
    en_seen = 0;
    @(negedge clk) ce = 1'b1;
    repeat (HALF) @(negedge clk);
    send_bits(cmd, 8, en_seen);
    en_seen = 0;
    send_bits(data, (ndata > 8) ? 8 : ndata, en_seen);
    for (int k = 8; k < ndata; k++) send_bits(8'h00, 1, en_seen);
    end_frame();
  endtask

  function automatic logic [7:0] pcmd(input logic [4:0] a, input bit rd);
    if (a < 5'd16) return {rd, 1'b1, a[3:0], 2'b01};
    else           return {rd, 3'b010, a[1:0], 2'b01};
  endfunction

  function automatic logic [7:0] scmd(input logic [1:0] i, input bit rd);
    return {rd, 3'b000, i, 2'b01};
  endfunction

  task automatic after_read(input string tag);
    check(exp_q.size() == 0 && mon_bits == 0, tag, 32'(mon_bits), 32'h0);
    check(sdo_en == 1'b0, {tag, " R5 pin released"}, 32'(sdo_en), 32'h0);
  endtask

  task automatic pram_write(input logic [4:0] a, input logic [7:0] d);
    int en;
    xfer(pcmd(a, 1'b0), d, 8, en);
    if (!wpm) pm[a] = d;
  endtask

  task automatic pram_read(input logic [4:0] a, input string tag);
    int en;
    exp_q.push_back(pm[a]); tag_q.push_back(tag);
    xfer(pcmd(a, 1'b1), 8'h00, 10, en);
    after_read(tag);
  endtask

  task automatic sec_write(input logic [1:0] i, input logic [7:0] d);
    int en;
    xfer(scmd(i, 1'b0), d, 8, en);
    if (!wpm) sm[{i, 3'b000} +: 8] = d;
  endtask

  task automatic sec_read(input logic [1:0] i, input string tag);
    int en;
    exp_q.push_back(sm[{i, 3'b000} +: 8]); tag_q.push_back(tag);
    xfer(scmd(i, 1'b1), 8'h00, 10, en);
    after_read(tag);
  endtask

  task automatic set_wp(input logic [7:0] d);
    int en;
    xfer(8'h35, d, 8, en);
    wpm = d[0];
  endtask

  task automatic pulse_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    sm = sm + 1;
  endtask

  task automatic ignored_cmd(input logic [7:0] cmd, input string tag);
    int en;
    xfer(cmd, 8'hFF, 10, en);
    check(en == 0 && mon_bits == 0, tag, 32'(en), 32'h0);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    check(1'b0, "watchdog expired", 32'h0, 32'h1);
    finish_up();
  end

  initial begin
    int en;
    for (int i = 0; i < 20; i++) pm[i] = 8'h00;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R11: reset state
    check(sdo_en == 1'b0, "R11 sdo_en after reset", 32'(sdo_en), 32'h0);
    for (int i = 0; i < 4; i++) sec_read(2'(i), "R11 seconds zero");
    pram_read(5'd0, "R11 pram first zero");
    pram_read(5'd19, "R11 pram last zero");

    // R3 / R4 / R1 / R6
    pram_write(5'd5, 8'hA7);
    pram_read(5'd5, "R3 low ram byte R1");
    pram_write(5'd18, 8'h3C);
    pram_read(5'd18, "R4 high ram byte R6");
    for (int i = 0; i < 20; i++) pram_write(5'(i), 8'((i * 37 + 11) & 255));
    for (int i = 0; i < 20; i++) pram_read(5'(i), (i < 16) ? "R3 sweep" : "R4 sweep");

    // R2: byte order of seconds
    sec_write(2'd0, 8'h11); sec_write(2'd1, 8'h22);
    sec_write(2'd2, 8'h33); sec_write(2'd3, 8'h44);
    for (int i = 0; i < 4; i++) sec_read(2'(i), "R2 seconds byte");

    // R8: ticks, carry, wrap
    repeat (3) pulse_tick();
    sec_read(2'd0, "R8 three ticks");
    sec_write(2'd0, 8'hFF); sec_write(2'd1, 8'hFF);
    pulse_tick();
    sec_read(2'd0, "R8 carry low");
    sec_read(2'd1, "R8 carry mid");
    sec_read(2'd2, "R8 carry into byte2");
    for (int i = 0; i < 4; i++) sec_write(2'(i), 8'hFF);
    pulse_tick();
    for (int i = 0; i < 4; i++) sec_read(2'(i), "R8 wrap to zero");

    // R7: write protect
    set_wp(8'h01);
    pram_write(5'd5, 8'h00);
    pram_read(5'd5, "R7 protected ram write ignored");
    sec_write(2'd2, 8'h99);
    sec_read(2'd2, "R7 protected seconds write ignored");
    pulse_tick();
    sec_read(2'd0, "R7 R8 tick counts under protect");
    xfer(8'h31, 8'h00, 8, en);
    pram_write(5'd7, 8'hEE);
    pram_read(5'd7, "R7 test register leaves protect set");
    set_wp(8'hFE);
    pram_write(5'd5, 8'h5E);
    pram_read(5'd5, "R7 protect cleared by bit0");

    // R10: unmatched commands
    ignored_cmd(8'hB1, "R10 read of test register");
    ignored_cmd(8'hB5, "R10 read of protect register");
    ignored_cmd(8'hBA, "R10 extended read");
    ignored_cmd(8'h38, "R10 extended write");
    ignored_cmd(8'h02, "R10 bad low bits");
    pram_read(5'd0, "R10 ram unchanged");
    sec_read(2'd0, "R10 seconds unchanged");
    pram_write(5'd9, 8'h42);
    pram_read(5'd9, "R10 protect still clear");

    // R9: abort mid data and mid command
    en = 0;
    @(negedge clk) ce = 1'b1;
    repeat (HALF) @(negedge clk);
    send_bits(pcmd(5'd5, 1'b0), 8, en);
    send_bits(8'hFF, 4, en);
    end_frame();
    pram_read(5'd5, "R9 aborted write not committed");
    @(negedge clk) ce = 1'b1;
    repeat (HALF) @(negedge clk);
    send_bits(8'hFF, 5, en);
    end_frame();
    check(sdo_en == 1'b0, "R9 no output after partial command", 32'(sdo_en), 32'h0);
    sec_read(2'd1, "R9 fresh command after abort");

    finish_up();
  end
endmodule